// File: doc/BRIEF.md
# Port Pin Interrupt Controller

This block turns the already-synchronized values of an eight-pin I/O port into a single interrupt request. Three per-pin configuration bits choose how each pin is watched: continuously for a high or low level, or once per transition on a rising edge, a falling edge, or either edge. Every pin that meets its condition shows up in a raw status vector. A per-pin mask then decides which of those conditions can reach the port's one interrupt output.

Edge detection compares each pin with its value one clock earlier. A detected edge is held in a status bit until software writes a 1 to that pin's position in the clear register. A level condition is never stored: it follows the pin for as long as the pin holds the chosen level. Software reaches the configuration and status through a small single-cycle register bus. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `ipc_port_irq`

## Requirements
- R1: Reset is synchronous and active high. It zeroes the mode, either-edge, polarity and mask registers and all stored edge status, so `irq_out` is low and every register reads 0 once reset ends.
- R2: A pin whose mode bit (offset 0) is 1 and whose polarity bit (offset 2) is 1 reports raw status 1 in the same cycle its input is high, and 0 while its input is low.
- R3: A pin whose mode bit is 1 and whose polarity bit is 0 reports raw status 1 exactly while its input is low.
- R4: A pin whose mode bit is 0, whose either-edge bit (offset 1) is 0 and whose polarity bit is 1 sets its raw status on the clock edge at which its input is 1 and was 0 one clock earlier. The bit stays set after the input falls again, until it is cleared.
- R5: With the mode, either-edge and polarity bits all 0, a pin latches on a 1-to-0 transition and ignores a 0-to-1 transition.
- R6: An either-edge bit of 1 on an edge-mode pin latches on both transitions, whatever its polarity bit holds.
- R7: Masked status (offset 5) equals raw status AND mask (offset 3). `irq_out` is high exactly when masked status is non-zero.
- R8: Writing to the clear register (offset 6) clears each stored edge bit whose write-data bit is 1 and leaves the bits written 0 unchanged. The clear has no effect on a pin in level mode.
- R9: When a new edge and a clear hit the same pin on the same clock edge, the raw status bit ends up set.
- R10: Raw status (offset 4) shows every pin that meets its condition, including pins whose mask bit is 0.
- R11: Offsets 0 to 3 read back the last value written. Offsets 4 and 5 are read-only. The clear offset and the unused offset 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Synchronized pin values, one bit per pin |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register at `bus_addr` (combinational) |
| irq_out | output | 1 | Port interrupt request |

## Verification
Several properties are checked on every cycle. A rising, falling or either-edge transition on an edge-mode pin must leave the stored bit set on the next cycle. A stored bit must hold while no clear arrives, and must drop when a clear arrives and no transition occurs. The interrupt must stay low while the mask is zero, and configuration must be zero after reset. Some behaviour only the bench's scenarios can show. Level status must follow the live pin in the same cycle. Clear bits written as 0 and clears aimed at level pins must do nothing. An edge that coincides with a clear must leave the bit set. Register readback and the read-as-zero offsets also come only from those scenarios, backed by a reference model compared against `irq_out` and `bus_rdata` every cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 3'd0,
        REG_ANY    = 3'd1,
        REG_POL    = 3'd2,
        REG_MASK   = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASKED = 3'd5,
        REG_CLEAR  = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    // Per-pin watch configuration
    typedef struct packed {
        logic level_mode;   // 1: level, 0: edge
        logic any_edge;     // 1: both transitions
        logic pol_high;     // 1: high level / rising, 0: low level / falling
    } pin_cfg_t;

    function automatic logic level_match(pin_cfg_t c, logic cur);
        return c.pol_high ? cur : ~cur;
    endfunction

    function automatic logic edge_match(pin_cfg_t c, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (c.any_edge)
            return rise | fall;
        return c.pol_high ? rise : fall;
    endfunction

endpackage

// File: rtl/ipc_regs.sv
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NPINS-1:0]     wdata,
    input  logic [NPINS-1:0]     raw_in,
    input  logic [NPINS-1:0]     masked_in,
    output logic [NPINS-1:0]     mode_q,
    output logic [NPINS-1:0]     any_q,
    output logic [NPINS-1:0]     pol_q,
    output logic [NPINS-1:0]     mask_q,
    output logic [NPINS-1:0]     clr_pulse,
    output logic [NPINS-1:0]     rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            any_q  <= '0;
            pol_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_MODE: mode_q <= wdata;
                REG_ANY:  any_q  <= wdata;
                REG_POL:  pol_q  <= wdata;
                REG_MASK: mask_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Clear acts on the same edge as the write
    assign clr_pulse = (wr_en && sel == REG_CLEAR) ? wdata : '0;

    always_comb begin
        case (sel)
            REG_MODE:   rdata = mode_q;
            REG_ANY:    rdata = any_q;
            REG_POL:    rdata = pol_q;
            REG_MASK:   rdata = mask_q;
            REG_RAW:    rdata = raw_in;
            REG_MASKED: rdata = masked_in;
            default:    rdata = '0;
        endcase
    end

    // R1: configuration is empty one cycle after reset
    a_r1_cfg_zero: assert property (@(posedge clk)
        rst |=> (mode_q == '0 && any_q == '0 && pol_q == '0 && mask_q == '0));

endmodule

// File: rtl/ipc_pin_detect.sv
module ipc_pin_detect
    import ipc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  pin_cfg_t cfg,
    input  logic     clr,
    output logic     raw
);

    logic prev_q;
    logic latch_q;
    logic hit;

    assign hit = edge_match(cfg, pin, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= pin;
            latch_q <= 1'b0;
        end else begin
            prev_q <= pin;
            if (cfg.level_mode)
                latch_q <= 1'b0;
            else if (hit)
                latch_q <= 1'b1;     // edge wins over a simultaneous clear
            else if (clr)
                latch_q <= 1'b0;
        end
    end

    assign raw = cfg.level_mode ? level_match(cfg, pin) : latch_q;

    // R4: rising transition on a rising-edge pin is stored
    a_r4_rise_stored: assert property (@(posedge clk) disable iff (rst)
        (!cfg.level_mode && !cfg.any_edge && cfg.pol_high && pin && !prev_q) |=> latch_q);

    // R4: stored bit holds without a clear
    a_r4_holds: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !clr && !cfg.level_mode) |=> latch_q);

    // R5: falling transition on a falling-edge pin is stored
    a_r5_fall_stored: assert property (@(posedge clk) disable iff (rst)
        (!cfg.level_mode && !cfg.any_edge && !cfg.pol_high && !pin && prev_q) |=> latch_q);

    // R6: any transition on an either-edge pin is stored
    a_r6_any_stored: assert property (@(posedge clk) disable iff (rst)
        (!cfg.level_mode && cfg.any_edge && (pin != prev_q)) |=> latch_q);

    // R8: clear with no transition drops the stored bit
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (latch_q && clr && (pin == prev_q)) |=> !latch_q);

endmodule

// File: rtl/ipc_combine.sv
module ipc_combine #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] raw_in,
    input  logic [NPINS-1:0] mask_in,
    output logic [NPINS-1:0] masked,
    output logic             irq_out
);

    assign masked  = raw_in & mask_in;
    assign irq_out = |masked;

    // R7: a fully masked port never interrupts
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (mask_in == '0) |-> !irq_out);

    // R10: an interrupt always has a raw cause behind it
    a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (raw_in != '0));

endmodule

// File: rtl/ipc_port_irq.sv
module ipc_port_irq
    import ipc_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPINS-1:0]     pin_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NPINS-1:0]     bus_wdata,
    output logic [NPINS-1:0]     bus_rdata,
    output logic                 irq_out
);

    logic [NPINS-1:0] mode_q;
    logic [NPINS-1:0] any_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] clr_pulse;
    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] masked;

    ipc_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .raw_in    (raw),
        .masked_in (masked),
        .mode_q    (mode_q),
        .any_q     (any_q),
        .pol_q     (pol_q),
        .mask_q    (mask_q),
        .clr_pulse (clr_pulse),
        .rdata     (bus_rdata)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{level_mode: mode_q[g], any_edge: any_q[g], pol_high: pol_q[g]};

        ipc_pin_detect u_det (
            .clk (clk),
            .rst (rst),
            .pin (pin_in[g]),
            .cfg (cfg),
            .clr (clr_pulse[g]),
            .raw (raw[g])
        );
    end

    ipc_combine #(.NPINS(NPINS)) u_comb (
        .clk     (clk),
        .rst     (rst),
        .raw_in  (raw),
        .mask_in (mask_q),
        .masked  (masked),
        .irq_out (irq_out)
    );

endmodule

// File: tb/ipc_port_irq_tb.sv
`timescale 1ns/1ps
module ipc_port_irq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in = '0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ipc_port_irq u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mode, m_any, m_pol, m_mask, m_prev, m_store;

    function automatic logic [7:0] m_raw();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_mode[i] ? (m_pol[i] ? pin_in[i] : !pin_in[i]) : m_store[i];
        return r;
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_any;
            3'd2: return m_pol;
            3'd3: return m_mask;
            3'd4: return m_raw();
            3'd5: return m_raw() & m_mask;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_any = 0; m_pol = 0; m_mask = 0; m_store = 0;
            m_prev = pin_in;
        end else begin
            for (int i = 0; i < 8; i++) begin
                bit up, dn, trig, wipe;
                up   = pin_in[i] && !m_prev[i];
                dn   = !pin_in[i] && m_prev[i];
                trig = m_any[i] ? (up || dn) : (m_pol[i] ? up : dn);
                wipe = bus_wr && bus_addr == 3'd6 && bus_wdata[i];
                if (m_mode[i])  m_store[i] = 1'b0;
                else if (trig)  m_store[i] = 1'b1;
                else if (wipe)  m_store[i] = 1'b0;
            end
            m_prev = pin_in;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_mode = bus_wdata;
                    3'd1: m_any  = bus_wdata;
                    3'd2: m_pol  = bus_wdata;
                    3'd3: m_mask = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model, away from the edge
    initial begin
        forever begin
            @(negedge clk); #1;
            if (!rst) begin
                n_tests++;
                if (irq_out !== (|m_read(3'd5))) begin
                    n_fail++;
                    $display("FAIL R7 model irq: actual %b expected %b", irq_out, |m_read(3'd5));
                end
                n_tests++;
                if (bus_rdata !== m_read(bus_addr)) begin
                    n_fail++;
                    $display("FAIL R11 model rdata @%0d: actual %h expected %h",
                             bus_addr, bus_rdata, m_read(bus_addr));
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; pin_in = '0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #1; chk(tag, {7'd0, irq_out}, {7'd0, exp});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        do_reset();
        // R1: reset state
        for (int a = 0; a < 6; a++) chk_rd("R1 reg after reset", 3'(a), 8'h00);
        chk_irq("R1 irq after reset", 1'b0);

        // R11: readback and read-as-zero
        wr(3'd1, 8'hA5); chk_rd("R11 any-edge readback", 3'd1, 8'hA5);
        wr(3'd6, 8'hFF); chk_rd("R11 clear reads zero", 3'd6, 8'h00);
        chk_rd("R11 offset 7 reads zero", 3'd7, 8'h00);
        wr(3'd1, 8'h00);

        // R2: level high on pin 0
        wr(3'd2, 8'h01); wr(3'd0, 8'h01); wr(3'd3, 8'h01);
        set_pins(8'h01); chk_rd("R2 level high seen", 3'd4, 8'h01);
        chk_irq("R7 irq on masked level", 1'b1);
        set_pins(8'h00); chk_rd("R2 level released", 3'd4, 8'h00);
        chk_irq("R7 irq drops", 1'b0);

        // R8: level pin ignores clear
        set_pins(8'h01);
        wr(3'd6, 8'h01); chk_rd("R8 clear ignored on level pin", 3'd4, 8'h01);

        // R3: level low on pin 1 (pins 0x01, pin1 low)
        wr(3'd0, 8'h03); chk_rd("R3 level low seen", 3'd4, 8'h03);
        set_pins(8'h03); chk_rd("R3 level low released", 3'd4, 8'h01);

        // R4: rising edge on pin 2
        do_reset();
        wr(3'd2, 8'h04);
        set_pins(8'h04); tick(); chk_rd("R4 rise stored", 3'd4, 8'h04);
        set_pins(8'h00); tick(); chk_rd("R4 stays after fall", 3'd4, 8'h04);
        chk_irq("R10 raw set but masked, no irq", 1'b0);
        chk_rd("R10 masked status empty", 3'd5, 8'h00);
        wr(3'd3, 8'h04); chk_rd("R7 masked status", 3'd5, 8'h04);
        chk_irq("R7 irq with mask", 1'b1);
        wr(3'd6, 8'h00); chk_rd("R8 zero clear no effect", 3'd4, 8'h04);
        wr(3'd6, 8'h04); chk_rd("R8 one clears", 3'd4, 8'h00);
        chk_irq("R8 irq gone after clear", 1'b0);

        // R5: falling edge on pin 3
        set_pins(8'h08); tick(); chk_rd("R5 rise ignored", 3'd4, 8'h00);
        set_pins(8'h00); tick(); chk_rd("R5 fall stored", 3'd4, 8'h08);

        // R6: either edge on pin 4, with polarity bit high too
        wr(3'd1, 8'h10);
        set_pins(8'h10); tick(); chk_rd("R6 rise stored", 3'd4, 8'h18);
        wr(3'd6, 8'h10); chk_rd("R6 cleared", 3'd4, 8'h08);
        set_pins(8'h00); tick(); chk_rd("R6 fall stored", 3'd4, 8'h18);
        wr(3'd2, 8'h14); wr(3'd6, 8'h18);
        set_pins(8'h10); tick(); chk_rd("R6 rise with pol high", 3'd4, 8'h10);
        wr(3'd6, 8'h10);
        set_pins(8'h00); tick(); chk_rd("R6 overrides polarity", 3'd4, 8'h10);

        // R9: edge and clear on the same clock edge (pin 5 rising)
        wr(3'd6, 8'hFF); wr(3'd2, 8'h34);
        @(negedge clk); pin_in = 8'h20; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h20;
        @(negedge clk); bus_wr = 1'b0;
        chk_rd("R9 edge beats clear", 3'd4, 8'h20);

        repeat (4) tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule